// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits between a serial-memory protocol engine and a nonvolatile array. Once the engine has decoded a write command and its word address, it raises a start strobe along with that address. It then hands over each received data byte with a one-cycle strobe. The controller holds the bytes in a small page latch. The array is touched only when the engine reports a stop condition. If a new start arrives first, the latched bytes are discarded and the array is never touched.

A page is `PAGE_BYTES` bytes wide. The upper address bits, above the in-page offset, are taken from the start address and never change. The offset starts at the low bits of the start address and advances by one for each byte. When it passes the last slot it wraps to slot 0, so later bytes overwrite earlier ones in the latch. A single-byte write is simply a page of one byte.

At a stop, if the protect input is low and at least one byte was received, the controller scans the page slots in ascending order, one per cycle. It issues a write only for slots that received a byte, and then holds a self-timed write period. Busy is high for the whole scan plus the hold. If protect is high at the stop, nothing is written and busy stays low.

The state machine has four states:
- IDLE: no transaction open.
- COLLECT: a transaction is open and bytes are being latched.
- COMMIT: the page slots are being scanned.
- HOLD: the write-cycle timer is running.

The transitions are:
- IDLE to COLLECT, on a start.
- COLLECT to COLLECT, on a restart, which clears the latch.
- COLLECT to COMMIT, on a stop with bytes latched and protect low.
- COLLECT to IDLE, on a stop with no bytes or with protect high.
- COMMIT to HOLD, after the last slot has been scanned.
- HOLD to IDLE, when the timer expires.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are low.
- R2: A start in IDLE or COLLECT opens a new transaction and discards every byte latched before it. An aborted transaction writes nothing.
- R3: Each write lands at address {start address bits above the offset, slot}, where the offset is log2(`PAGE_BYTES`) bits wide. A single byte is written to exactly the start address.
- R4: The slot begins at the start address offset, advances by one per byte, and wraps from `PAGE_BYTES`-1 to 0. A later byte in the same slot replaces the earlier one.
- R5: Nothing is written before the stop. At a stop with protect low, exactly one write is issued for each slot that received a byte, in ascending slot order. Array locations that received no byte are never written.
- R6: When `wp_i` is high in the cycle of the stop, no write is issued and `busy_o` stays low.
- R7: A committing stop raises `busy_o` in the cycle after the stop. `busy_o` stays high for exactly `PAGE_BYTES` + `WRITE_CYCLES` cycles. `busy_o` never rises without a stop.
- R8: While `busy_o` is high, start, byte and stop strobes are ignored. A stop that follows the busy period then causes no new commit.
- R9: A byte or stop strobe in IDLE has no effect. A stop after a start with no bytes returns to IDLE without writes or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start_i | input | 1 | Opens a write transaction at `wr_addr_i` |
| wr_addr_i | input | ADDR_W | Start word address |
| byte_vld_i | input | 1 | One received data byte is present |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Stop condition seen on the bus |
| wp_i | input | 1 | Write protect, high inhibits the commit |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Commit scan or write-cycle hold in progress |

## Verification
The bench sends more than a page of bytes from a mid-page start. A design that carried the offset into the upper bits would write into the next page, and one that kept the first value would leave stale data where the later byte belongs. It aborts a transaction with a restart, stops with protect high, and stops with no bytes; a design that wrote on abort or under protect would change the shadow array or raise busy. It strobes start, bytes and stop inside the busy window and stops again afterwards. A design that listened while busy would then perform an extra commit. It measures the exact busy length, which an off-by-one timer would miss by a cycle, and it compares the entire array at the end to catch writes to slots that received no byte.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_COMMIT  = 2'd2,
        ST_HOLD    = 2'd3
    } pwb_state_e;
endpackage

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              wr_i,
    input  logic [OFS_W-1:0]  wr_slot_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [OFS_W-1:0]  rd_slot_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              any_o
);
    logic [PAGE_BYTES-1:0] valid_vec;
    logic [DATA_W-1:0]     data_arr [PAGE_BYTES];

    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
        logic              vld_q;
        logic [DATA_W-1:0] dat_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                dat_q <= '0;
            end else if (clear_i) begin
                vld_q <= 1'b0;
            end else if (wr_i && wr_slot_i == OFS_W'(s)) begin
                vld_q <= 1'b1;
                dat_q <= data_i;
            end
        end

        assign valid_vec[s] = vld_q;
        assign data_arr[s]  = dat_q;
    end

    assign rd_valid_o = valid_vec[rd_slot_i];
    assign rd_data_o  = data_arr[rd_slot_i];
    assign any_o      = |valid_vec;
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
    parameter int CYCLES    = 1000,
    localparam int CNT_W    = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CNT_W'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
    import pwb_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 16,      // power of two
    parameter int WRITE_CYCLES = 1000000  // hold length in clocks
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic              busy_o
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int HI_W  = ADDR_W - OFS_W;
    localparam logic [OFS_W-1:0] LAST_SLOT = OFS_W'(PAGE_BYTES - 1);

    pwb_state_e        state_q, state_d;
    logic [HI_W-1:0]   page_hi_q;
    logic [OFS_W-1:0]  ptr_q;
    logic [OFS_W-1:0]  scan_q;
    logic              take_start, take_byte;
    logic              latch_any, slot_valid;
    logic [DATA_W-1:0] slot_data;
    logic              timer_load, timer_done;

    // A start is only heard while no commit is running; a byte is dropped
    // when a start or stop shares its cycle.
    assign take_start = wr_start_i && (state_q == ST_IDLE || state_q == ST_COLLECT);
    assign take_byte  = byte_vld_i && !wr_start_i && !stop_i && (state_q == ST_COLLECT);
    assign timer_load = (state_q == ST_COMMIT) && (scan_q == LAST_SLOT);

    pwb_page_latch #(
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (take_start),
        .wr_i       (take_byte),
        .wr_slot_i  (ptr_q),
        .data_i     (byte_i),
        .rd_slot_i  (scan_q),
        .rd_data_o  (slot_data),
        .rd_valid_o (slot_valid),
        .any_o      (latch_any)
    );

    pwb_cycle_timer #(
        .CYCLES (WRITE_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (timer_load),
        .done_o (timer_done)
    );

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_start_i) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (wr_start_i) begin
                    state_d = ST_COLLECT;
                end else if (stop_i) begin
                    state_d = (latch_any && !wp_i) ? ST_COMMIT : ST_IDLE;
                end
            end
            ST_COMMIT: begin
                if (scan_q == LAST_SLOT) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (timer_done) state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Address and scan registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_hi_q <= '0;
            ptr_q     <= '0;
            scan_q    <= '0;
        end else begin
            if (take_start) begin
                page_hi_q <= wr_addr_i[ADDR_W-1:OFS_W];
                ptr_q     <= wr_addr_i[OFS_W-1:0];
            end else if (take_byte) begin
                ptr_q     <= ptr_q + 1'b1;   // wraps inside the page
            end
            if (state_q == ST_COMMIT) scan_q <= scan_q + 1'b1;
            else                      scan_q <= '0;
        end
    end

    // Outputs.
    always_comb begin
        mem_we_o   = (state_q == ST_COMMIT) && slot_valid;
        mem_addr_o = {page_hi_q, scan_q};
        mem_data_o = slot_data;
        busy_o     = (state_q == ST_COMMIT) || (state_q == ST_HOLD);
    end
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 16,
    localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_i,
    input logic              wp_i,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              busy_o
);
    // R5: array writes only inside a busy period
    p_we_inside_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    // R5: writes within one commit go to strictly rising slots
    p_slot_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o[OFS_W-1:0] > $past(mem_addr_o[OFS_W-1:0])));

    // R3: page bits stay fixed while busy
    p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:OFS_W]));

    // R7: busy only begins right after a stop
    p_busy_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));

    // R6: a protected stop never starts a commit
    p_protect_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && wp_i) |=> !$rose(busy_o));
endmodule

bind page_write_buffer pwb_checker #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_i     (stop_i),
    .wp_i       (wp_i),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .busy_o     (busy_o)
);

// File: tb/tb_page_write_buffer.sv
module tb_page_write_buffer;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int PB = 16;
    localparam int WC = 12;
    localparam int MEMN = 1 << AW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          wr_start, byte_vld, stop, wp;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] bdata;
    logic          mem_we, busy;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;

    page_write_buffer #(
        .ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_start_i(wr_start), .wr_addr_i(wr_addr),
        .byte_vld_i(byte_vld), .byte_i(bdata), .stop_i(stop), .wp_i(wp),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
        .busy_o(busy)
    );

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] act_mem [MEMN];
    logic [7:0] exp_mem [MEMN];
    int   wr_count, busy_cycles, order_err;
    logic last_we = 1'b0;
    logic [3:0] last_lo = '0;

    int   m_base, m_ptr;
    logic [7:0] m_buf [PB];
    logic m_mask [PB];

    // Port monitor: shadow array, write count, order, busy length.
    always @(negedge clk) begin
        if (mem_we) begin
            act_mem[mem_addr] = mem_data;
            wr_count++;
            if (last_we && mem_addr[3:0] <= last_lo) order_err++;
            last_lo = mem_addr[3:0];
        end
        last_we = mem_we;
        if (busy) busy_cycles++;
    end

    function automatic logic [7:0] init_byte(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic int mask_count();
        int c = 0;
        for (int i = 0; i < PB; i++) if (m_mask[i]) c++;
        return c;
    endfunction

    function automatic int exp_busy(input int cnt, input logic prot);
        return (cnt > 0 && !prot) ? PB + WC : 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drv_start(input logic [AW-1:0] a);
        wr_start = 1'b1; wr_addr = a;
        @(negedge clk);
        wr_start = 1'b0;
    endtask

    task automatic drv_byte(input logic [7:0] d);
        byte_vld = 1'b1; bdata = d;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic drv_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic t_start(input logic [AW-1:0] a);
        m_base = int'(a[AW-1:4]);
        m_ptr  = int'(a[3:0]);
        for (int i = 0; i < PB; i++) m_mask[i] = 1'b0;
        drv_start(a);
    endtask

    task automatic t_byte(input logic [7:0] d);
        m_buf[m_ptr]  = d;
        m_mask[m_ptr] = 1'b1;
        m_ptr = (m_ptr + 1) % PB;
        drv_byte(d);
    endtask

    task automatic t_commit(input string req, input bit disturb);
        int n, eb, ew, mism;
        n  = mask_count();
        eb = exp_busy(n, wp);
        ew = (eb != 0) ? n : 0;
        if (eb != 0)
            for (int i = 0; i < PB; i++)
                if (m_mask[i]) exp_mem[m_base * PB + i] = m_buf[i];
        wr_count = 0; busy_cycles = 0; order_err = 0;
        drv_stop();
        if (disturb) begin
            drv_start(11'h7F0);
            drv_byte(8'hEE);
            drv_byte(8'hDD);
            drv_stop();
        end
        for (int g = 0; g < 400 && busy; g++) @(negedge clk);
        chk(busy_cycles == eb, {req, " busy length R7"}, busy_cycles, eb);
        chk(wr_count == ew, {req, " write count R5"}, wr_count, ew);
        chk(order_err == 0, {req, " ascending order R5"}, order_err, 0);
        mism = 0;
        for (int i = 0; i < PB; i++)
            if (act_mem[m_base * PB + i] !== exp_mem[m_base * PB + i]) mism++;
        chk(mism == 0, {req, " page contents R3"}, mism, 0);
    endtask

    task automatic t_quiet(input string req);
        wr_count = 0; busy_cycles = 0;
        drv_stop();
        repeat (3) @(negedge clk);
        chk(busy_cycles == 0, {req, " no busy"}, busy_cycles, 0);
        chk(wr_count == 0, {req, " no write"}, wr_count, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R7 watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int mism;
        void'($urandom(32'd20240611));
        for (int a = 0; a < MEMN; a++) begin
            act_mem[a] = init_byte(a);
            exp_mem[a] = init_byte(a);
        end
        rst_n = 1'b0; wr_start = 0; byte_vld = 0; stop = 0; wp = 0;
        wr_addr = '0; bdata = '0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(mem_we == 1'b0, "R1 write strobe after reset", int'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: single byte goes to exactly its address
        t_start(11'h123);
        t_byte(8'hA5);
        t_commit("R3 byte write", 1'b0);
        chk(act_mem[11'h123] == 8'hA5, "R3 byte value", int'(act_mem[11'h123]), 165);

        // R4: twenty bytes from a mid-page offset wrap and overwrite
        t_start(11'h2FA);
        for (int i = 0; i < 20; i++) t_byte(8'(i * 3 + 1));
        t_commit("R4 wrap", 1'b0);
        chk(act_mem[11'h2FA] == 8'd49, "R4 last byte wins", int'(act_mem[11'h2FA]), 49);

        // R6: protect high at stop
        wp = 1'b1;
        t_start(11'h400);
        for (int i = 0; i < 5; i++) t_byte(8'(8'h90 + i));
        t_commit("R6 protected", 1'b0);
        wp = 1'b0;

        // R2: restart discards first bytes
        t_start(11'h500);
        for (int i = 0; i < 4; i++) t_byte(8'(8'h40 + i));
        t_start(11'h533);
        t_byte(8'h77);
        t_byte(8'h78);
        t_commit("R2 abort", 1'b0);
        mism = 0;
        for (int i = 0; i < PB; i++)
            if (act_mem[11'h500 + i] !== exp_mem[11'h500 + i]) mism++;
        chk(mism == 0, "R2 aborted page untouched", mism, 0);

        // R9: empty transaction, stray byte and stop in IDLE
        t_start(11'h600);
        t_commit("R9 empty", 1'b0);
        drv_byte(8'h11);
        t_quiet("R9 idle strobes");

        // R8: strobes during busy are ignored
        t_start(11'h0A8);
        for (int i = 0; i < 3; i++) t_byte(8'(8'hC0 + i));
        t_commit("R8 disturbed", 1'b1);
        t_quiet("R8 after busy");

        // Random transactions
        for (int k = 0; k < 25; k++) begin
            int n;
            logic [AW-1:0] a;
            wp = (($urandom % 4) == 0);
            if (($urandom % 5) == 0) begin
                t_start(AW'($urandom));
                for (int i = 0; i < 3; i++) t_byte(8'($urandom));
            end
            a = AW'($urandom);
            n = $urandom % 21;
            t_start(a);
            for (int i = 0; i < n; i++) begin
                t_byte(8'($urandom));
                repeat ($urandom % 3) @(negedge clk);
            end
            t_commit("R5 random", 1'b0);
            wp = 1'b0;
        end

        mism = 0;
        for (int a = 0; a < MEMN; a++) if (act_mem[a] !== exp_mem[a]) mism++;
        chk(mism == 0, "R5 no stray writes in array", mism, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule